// File: doc/BRIEF.md
# Microprogrammed Two-Operand Averager

This block forms the truncated mean of two unsigned operands. It adds them and then shifts the sum right by one bit. A small datapath does the work. It holds two operand registers, an adder unit, a logical right-shift unit, an accumulator and a result register. A microcode sequencer drives that datapath. Each microcode row holds a next-address field, a condition select and a set of control bits. The sequencer advances to the next address when the selected condition holds and stays put otherwise. The sum is formed modulo 2^W, so the adder's carry-out is discarded before the shift.

A build-time parameter selects one of two microprograms. In the fast variant, the adder output feeds the shifter directly, and one compute row produces the mean. In the low-cost variant, the computation takes two rows: one row stores the sum, and the next row shifts the stored sum. The low-cost variant is one cycle slower. The caller places A and B on the ports and pulses start. The block then captures A and B on successive cycles. It raises done for one cycle, and at that point the result port carries the mean.

Top module: `avg_microprog`

## Requirements
- R1: When done is high, result equals ((A + B) mod 2^W) >> 1, with A and B read as unsigned W-bit values. The most significant result bit is therefore always 0.
- R2: With FAST=1, done rises exactly 4 rising clock edges after the edge that accepted start.
- R3: With FAST=0, done rises exactly 5 rising clock edges after the edge that accepted start.
- R4: busy is high in every cycle from the edge that accepts start up to the cycle before done. busy is low while done is high and while the block is idle. busy is never high together with done.
- R5: done stays high for exactly one cycle per accepted start.
- R6: start is accepted only while both busy and done are low. A start pulse during an operation leaves the timing and the result of that operation unchanged.
- R7: During and right after reset (rst_n low), busy is 0, done is 0 and result is 0.
- R8: result changes only on the edge that enters the done cycle. Between operations it holds its value, whatever happens on a_in and b_in.
- R9: a_in is captured at the end of the first busy cycle and b_in at the end of the second. Later changes to either input do not affect the result of the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a new average; sampled while idle |
| a_in | input | W | First unsigned operand |
| b_in | input | W | Second unsigned operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse; result is valid |
| result | output | W | Truncated mean, held between operations |

## Verification
The exhaustive sweep covers all 256 operand pairs on both variants at once. It separates the correct dropped-carry arithmetic from a version that keeps the carry: pairs whose sum reaches 16 give different answers under the two. Because every pair is tried, a swapped or stuck shifter bit also shows up. Random operations mix two disturbances: a start pulse in the middle of an operation, and operand changes after each capture point. Each operation checks the exact busy/done profile cycle by cycle, which tells a wrong latency or a restarted sequence apart from a correct run. An idle phase with changing inputs and no start shows whether the result register updates outside its write row.

// File: rtl/avg_pkg.sv
// Shared types and the microcode contents for the averager.
// Assumes a 3-bit microcode address; both programs fit in 7 rows.
package avg_pkg;

    localparam int UA_W = 3;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_ADD    = 2'd1,
        OP_SHR    = 2'd2,
        OP_ADDSHR = 2'd3
    } alu_op_e;

    typedef enum logic {
        CND_ALWAYS = 1'b0,
        CND_START  = 1'b1
    } cond_e;

    typedef struct packed {
        logic [UA_W-1:0] nxt;
        cond_e           cond;
        logic            ld_a;
        logic            ld_b;
        alu_op_e         op;
        logic            wr_res;
        logic            busy;
        logic            done;
    } uinstr_t;

    // Build one microcode row: fields in struct order.
    function automatic uinstr_t mk_row(input logic [UA_W-1:0] nxt, input cond_e cond,
                                       input logic ld_a, input logic ld_b, input alu_op_e op,
                                       input logic wr_res, input logic busy, input logic done);
        uinstr_t r;
        r.nxt    = nxt;
        r.cond   = cond;
        r.ld_a   = ld_a;
        r.ld_b   = ld_b;
        r.op     = op;
        r.wr_res = wr_res;
        r.busy   = busy;
        r.done   = done;
        return r;
    endfunction

    // Microcode contents: the fast program chains add and shift in one row,
    // the low-cost program spends one row per functional unit.
    function automatic uinstr_t rom_row(input bit fast, input logic [UA_W-1:0] addr);
        uinstr_t r;
        r = mk_row('0, CND_ALWAYS, 1'b0, 1'b0, OP_HOLD, 1'b0, 1'b0, 1'b0);
        if (fast) begin
            case (addr)
                3'd0: r = mk_row(3'd1, CND_START,  1'b0, 1'b0, OP_HOLD,   1'b0, 1'b0, 1'b0);
                3'd1: r = mk_row(3'd2, CND_ALWAYS, 1'b1, 1'b0, OP_HOLD,   1'b0, 1'b1, 1'b0);
                3'd2: r = mk_row(3'd3, CND_ALWAYS, 1'b0, 1'b1, OP_HOLD,   1'b0, 1'b1, 1'b0);
                3'd3: r = mk_row(3'd4, CND_ALWAYS, 1'b0, 1'b0, OP_ADDSHR, 1'b0, 1'b1, 1'b0);
                3'd4: r = mk_row(3'd5, CND_ALWAYS, 1'b0, 1'b0, OP_HOLD,   1'b1, 1'b1, 1'b0);
                3'd5: r = mk_row(3'd0, CND_ALWAYS, 1'b0, 1'b0, OP_HOLD,   1'b0, 1'b0, 1'b1);
                default: r = mk_row(3'd0, CND_ALWAYS, 1'b0, 1'b0, OP_HOLD, 1'b0, 1'b0, 1'b0);
            endcase
        end else begin
            case (addr)
                3'd0: r = mk_row(3'd1, CND_START,  1'b0, 1'b0, OP_HOLD, 1'b0, 1'b0, 1'b0);
                3'd1: r = mk_row(3'd2, CND_ALWAYS, 1'b1, 1'b0, OP_HOLD, 1'b0, 1'b1, 1'b0);
                3'd2: r = mk_row(3'd3, CND_ALWAYS, 1'b0, 1'b1, OP_HOLD, 1'b0, 1'b1, 1'b0);
                3'd3: r = mk_row(3'd4, CND_ALWAYS, 1'b0, 1'b0, OP_ADD,  1'b0, 1'b1, 1'b0);
                3'd4: r = mk_row(3'd5, CND_ALWAYS, 1'b0, 1'b0, OP_SHR,  1'b0, 1'b1, 1'b0);
                3'd5: r = mk_row(3'd6, CND_ALWAYS, 1'b0, 1'b0, OP_HOLD, 1'b1, 1'b1, 1'b0);
                3'd6: r = mk_row(3'd0, CND_ALWAYS, 1'b0, 1'b0, OP_HOLD, 1'b0, 1'b0, 1'b1);
                default: r = mk_row(3'd0, CND_ALWAYS, 1'b0, 1'b0, OP_HOLD, 1'b0, 1'b0, 1'b0);
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/avg_adder.sv
// Adder functional unit: W-bit unsigned sum, carry-out discarded.
// Assumes both inputs are unsigned and of equal width.
module avg_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum
);
    // Modulo-2^W addition; the carry bit is not kept.
    always_comb sum = x + y;
endmodule

// File: rtl/avg_shifter.sv
// Shift functional unit: logical right shift by one, constant 0 into the MSB.
// Assumes W >= 2.
module avg_shifter #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);
    // Drop the LSB and fill the vacated top bit with 0.
    always_comb y = {1'b0, x[W-1:1]};
endmodule

// File: rtl/avg_useq.sv
// Microcode sequencer: holds the micro-PC, reads the microcode row and
// decodes its control fields. Advances to the row's next address when its
// condition holds, otherwise repeats the current row.
// Assumes start is synchronous to clk.
module avg_useq
    import avg_pkg::*;
#(
    parameter bit FAST = 1'b1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    output logic    ld_a,
    output logic    ld_b,
    output alu_op_e op,
    output logic    wr_res,
    output logic    busy,
    output logic    done
);
    logic [UA_W-1:0] upc;
    uinstr_t         uw;
    logic            adv;

    // Read the microcode row for the current address.
    always_comb uw = rom_row(FAST, upc);

    // Evaluate the row's condition select.
    always_comb begin
        case (uw.cond)
            CND_START: adv = start;
            default:   adv = 1'b1;
        endcase
    end

    // Micro-PC update: branch on condition, otherwise stay.
    always_ff @(posedge clk) begin
        if (!rst_n)   upc <= '0;
        else if (adv) upc <= uw.nxt;
    end

    // Expose the control fields.
    always_comb begin
        ld_a   = uw.ld_a;
        ld_b   = uw.ld_b;
        op     = uw.op;
        wr_res = uw.wr_res;
        busy   = uw.busy;
        done   = uw.done;
    end
endmodule

// File: rtl/avg_datapath.sv
// Datapath: operand registers, adder, shifter, accumulator and result
// register. The op code chooses add, shift of the accumulator, or chained
// add-then-shift. Assumes control bits come from the sequencer in the same cycle.
module avg_datapath
    import avg_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         ld_a,
    input  logic         ld_b,
    input  alu_op_e      op,
    input  logic         wr_res,
    output logic [W-1:0] result
);
    logic [W-1:0] ra, rb, acc, acc_nxt, res_q;
    logic [W-1:0] sum, sh_in, sh_out;

    avg_adder #(.W(W)) u_add (.x(ra), .y(rb), .sum(sum));

    // Shifter source: the accumulator in a shift-only row, else the adder.
    always_comb sh_in = (op == OP_SHR) ? acc : sum;

    avg_shifter #(.W(W)) u_shr (.x(sh_in), .y(sh_out));

    // Pick the accumulator's next value from the row's op code.
    always_comb begin
        case (op)
            OP_ADD:    acc_nxt = sum;
            OP_SHR:    acc_nxt = sh_out;
            OP_ADDSHR: acc_nxt = sh_out;
            default:   acc_nxt = acc;
        endcase
    end

    // Operand and accumulator registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ra  <= '0;
            rb  <= '0;
            acc <= '0;
        end else begin
            if (ld_a) ra <= a_in;
            if (ld_b) rb <= b_in;
            acc <= acc_nxt;
        end
    end

    // Result register, written only by the write row.
    always_ff @(posedge clk) begin
        if (!rst_n)      res_q <= '0;
        else if (wr_res) res_q <= acc;
    end

    always_comb result = res_q;
endmodule

// File: rtl/avg_microprog.sv
// Top level of the microprogrammed averager. FAST=1 chains add and shift in
// one row (4-cycle program); FAST=0 uses separate rows (5-cycle program).
// Assumes operands stay valid until their capture cycles.
module avg_microprog
    import avg_pkg::*;
#(
    parameter int W    = 4,
    parameter bit FAST = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);
    logic    ld_a, ld_b, wr_res;
    alu_op_e op;

    avg_useq #(.FAST(FAST)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ld_a(ld_a), .ld_b(ld_b), .op(op), .wr_res(wr_res),
        .busy(busy), .done(done)
    );

    avg_datapath #(.W(W)) u_dp (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .ld_a(ld_a), .ld_b(ld_b), .op(op), .wr_res(wr_res),
        .result(result)
    );
endmodule

// File: rtl/avg_microprog_chk.sv
// Checker bound to the averager: handshake, latency and result-register rules.
module avg_microprog_chk #(
    parameter int W    = 4,
    parameter bit FAST = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result
);
    localparam int LAT = FAST ? 4 : 5;

    logic [3:0] bcnt;

    // Count the busy cycles of the current operation.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) bcnt <= '0;
        else                 bcnt <= bcnt + 4'd1;
    end

    // R1
    result_msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result[W-1] == 1'b0));

    // R2 R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bcnt == 4'(LAT)));

    // R4
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R6
    busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);
endmodule

bind avg_microprog avg_microprog_chk #(.W(W), .FAST(FAST)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .done(done), .result(result)
);

// File: tb/avg_microprog_bench.sv
module avg_microprog_bench;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         busy_f, done_f, busy_s, done_s;
    logic [W-1:0] res_f, res_s;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    avg_microprog #(.W(W), .FAST(1'b1)) u_avg_microprog (
        .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
        .busy(busy_f), .done(done_f), .result(res_f));

    avg_microprog #(.W(W), .FAST(1'b0)) u_avg_microprog_slow (
        .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
        .busy(busy_s), .done(done_s), .result(res_s));

    function automatic logic [W-1:0] exp_avg(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] s;
        s = a + b;
        return s >> 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One operation on both variants; optional mid-run start and late operand changes.
    task automatic do_op(input logic [W-1:0] a, input logic [W-1:0] b,
                         input bit poke, input bit late);
        int lat_f = 0, lat_s = 0;
        bit prof_f = 1'b1, prof_s = 1'b1;
        logic [W-1:0] ef;
        ef = exp_avg(a, b);
        @(negedge clk);
        a_in = a; b_in = b; start = 1'b1;
        @(posedge clk);
        for (int k = 1; k <= 7; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 1) begin start = 1'b0; if (late) a_in = ~a; end
            if (k == 2) begin if (poke) start = 1'b1; if (late) b_in = ~b; end
            if (k == 3) start = 1'b0;
            if (done_f && lat_f == 0) begin lat_f = k; chk(res_f == ef, "R1/R9 fast result", res_f, ef); end
            if (done_s && lat_s == 0) begin lat_s = k; chk(res_s == ef, "R1/R9 slow result", res_s, ef); end
            if (busy_f != (k < 4) || done_f != (k == 4)) prof_f = 1'b0;
            if (busy_s != (k < 5) || done_s != (k == 5)) prof_s = 1'b0;
        end
        chk(lat_f == 4, "R2 fast latency", lat_f, 4);
        chk(lat_s == 5, "R3 slow latency", lat_s, 5);
        chk(prof_f, "R4/R5/R6 fast busy-done profile", prof_f, 1);
        chk(prof_s, "R4/R5/R6 slow busy-done profile", prof_s, 1);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, 100000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] hold_f, hold_s;
        void'($urandom(32'd20240917));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7: reset state
        chk(!busy_f && !done_f && res_f == 0, "R7 fast reset", {busy_f, done_f}, 0);
        chk(!busy_s && !done_s && res_s == 0, "R7 slow reset", {busy_s, done_s}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_f && !busy_s, "R7 idle after reset", {busy_f, busy_s}, 0);

        // R1: corner cases
        do_op(4'd15, 4'd15, 1'b0, 1'b0);
        do_op(4'd0, 4'd0, 1'b0, 1'b0);
        do_op(4'd8, 4'd8, 1'b0, 1'b0);
        do_op(4'd15, 4'd1, 1'b0, 1'b0);

        // R1 R2 R3: exhaustive sweep
        for (int i = 0; i < 256; i++)
            do_op(W'(i >> 4), W'(i & 15), 1'b0, 1'b0);

        // R6 R9: random operations with disturbances
        for (int i = 0; i < 150; i++)
            do_op(W'($urandom), W'($urandom), 1'($urandom), 1'($urandom));

        // R8: idle input changes leave the result alone
        hold_f = res_f;
        hold_s = res_s;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            a_in = W'($urandom);
            b_in = W'($urandom);
        end
        @(negedge clk);
        chk(res_f == hold_f, "R8 fast result held", res_f, hold_f);
        chk(res_s == hold_s, "R8 slow result held", res_s, hold_s);
        chk(!busy_f && !done_f && !busy_s && !done_s, "R6 no spurious start", {busy_f, done_f, busy_s, done_s}, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule